// File: doc/BRIEF.md
# NMI Flag and Watchdog Controller

This block gathers non-maskable fault events for one CPU, such as a clock failure or a watchdog reset in a peer core. Each event source has its own sticky flag. When any source fires, a global interrupt bit is also set, and that bit drives the NMI request line to the CPU. While at least one source flag is pending, a counter advances on every system clock. If software does not acknowledge the faults before the counter reaches a programmable period, the block emits a one-cycle NMI watchdog reset pulse.

Software controls the block through a small register window. It turns the block on once at startup through a write-once enable. It acknowledges each source by writing ones to a separate clear register. It may drop the global bit only after every source flag is already clear. It can also program the period and read the live counter.

Top module: `nmi_guard`

## Requirements
- R1: After reset, every flag, the global bit, the counter and the enable read as zero, the period reads PERIOD_RST (default 16), and both `nmi_req_o` and `nmi_wdrst_o` are low.
- R2: Writing 1 to bit 0 at address 0 (CTRL) sets the enable. A later write of 0 leaves it at 1, and only reset clears it. While the enable is 0, the sources set no flag.
- R3: A source i that is high at a clock edge while the block is enabled sets flag bit i+1 and the global bit (bit 0) of the flag register at address 1. `nmi_req_o` is high from that edge onward.
- R4: Writes to the flag register at address 1 change nothing.
- R5: Writing to address 2 (FLAGCLR) with bit i+1 set clears source flag i. Bits written as zero leave their flags unchanged.
- R6: If a source is high in the same cycle that its flag is cleared, the flag stays set.
- R7: A write of bit 0 to FLAGCLR clears the global bit only if every source flag was already clear before that write. Otherwise the global bit and `nmi_req_o` stay high.
- R8: While any source flag is set, the counter at address 4 reads 0 in the cycle after the flag first sets and increases by one on each later edge.
- R9: When the counter reaches the period (address 3), `nmi_wdrst_o` is high for exactly one cycle, P cycles after the flag-setting edge. The counter then holds.
- R10: Once all source flags are clear, the counter returns to zero one cycle later. A later fault starts a new count that can pulse again.
- R11: The period register at address 3 reads back the value last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | NUM_SRC | Fault event sources, active high |
| reg_addr_i | input | 3 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data (combinational on address) |
| nmi_req_o | output | 1 | NMI request to the CPU, equal to the global bit |
| nmi_wdrst_o | output | 1 | One-cycle NMI watchdog reset pulse |

## Verification
A flag that fails to stick, or a set that loses to a clear, shows up at the flag register read on the very next cycle. A counter that skips a step or fails to restart moves the reset pulse away from its exact cycle, P edges after the fault. The bench checks the pulse cycle by cycle to catch this. A global bit that clears too early drops `nmi_req_o` one edge after the premature clear write. A pulse that repeats shows up as `nmi_wdrst_o` still high one cycle later.

// File: rtl/nmi_guard_pkg.sv
package nmi_guard_pkg;

  localparam int unsigned REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_CTRL    = 3'd0,
    REG_FLAG    = 3'd1,
    REG_FLAGCLR = 3'd2,
    REG_PERIOD  = 3'd3,
    REG_COUNT   = 3'd4
  } nmi_reg_e;

endpackage

// File: rtl/nmi_guard_regif.sv
module nmi_guard_regif
  import nmi_guard_pkg::*;
#(
  parameter int unsigned NUM_SRC    = 4,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned PERIOD_RST = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic                  wr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic [NUM_SRC-1:0]    flags_i,
  input  logic                  glob_i,
  input  logic [CNT_W-1:0]      cnt_i,
  output logic                  enable_o,
  output logic [CNT_W-1:0]      period_o,
  output logic [NUM_SRC-1:0]    clr_mask_o,
  output logic                  clr_glob_o,
  output logic [DATA_W-1:0]     rdata_o
);

  localparam int unsigned FLAG_HI = NUM_SRC;

  logic             enable_q, enable_d;
  logic [CNT_W-1:0] period_q, period_d;
  logic             wr_ctrl, wr_clr, wr_period;

  always_comb begin
    wr_ctrl   = wr_i && (addr_i == REG_CTRL);
    wr_clr    = wr_i && (addr_i == REG_FLAGCLR);
    wr_period = wr_i && (addr_i == REG_PERIOD);
  end

  always_comb begin
    enable_d = enable_q | (wr_ctrl & wdata_i[0]);
    period_d = period_q;
    if (wr_period) begin
      period_d = wdata_i[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_q <= 1'b0;
      period_q <= CNT_W'(PERIOD_RST);
    end else begin
      enable_q <= enable_d;
      period_q <= period_d;
    end
  end

  always_comb begin
    clr_mask_o = wr_clr ? wdata_i[FLAG_HI:1] : '0;
    clr_glob_o = wr_clr & wdata_i[0];
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_CTRL:   rdata_o[0] = enable_q;
      REG_FLAG: begin
        rdata_o[0]         = glob_i;
        rdata_o[FLAG_HI:1] = flags_i;
      end
      REG_PERIOD: rdata_o[CNT_W-1:0] = period_q;
      REG_COUNT:  rdata_o[CNT_W-1:0] = cnt_i;
      default:    rdata_o = '0;
    endcase
  end

  assign enable_o = enable_q;
  assign period_o = period_q;

endmodule

// File: rtl/nmi_guard_flags.sv
module nmi_guard_flags #(
  parameter int unsigned NUM_SRC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] clr_mask_i,
  input  logic               clr_glob_i,
  output logic [NUM_SRC-1:0] flags_o,
  output logic               glob_o
);

  logic [NUM_SRC-1:0] flags_q, flags_d, set_vec;
  logic               glob_q, glob_d;
  logic               any_set, all_clear;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    always_comb begin
      set_vec[i] = enable_i & src_i[i];
      // A new event outranks an acknowledge in the same cycle.
      flags_d[i] = set_vec[i] | (flags_q[i] & ~clr_mask_i[i]);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flags_q[i] <= 1'b0;
      end else begin
        flags_q[i] <= flags_d[i];
      end
    end
  end

  always_comb begin
    any_set   = |set_vec;
    all_clear = (flags_q == '0);
    glob_d    = any_set | (glob_q & ~(clr_glob_i & all_clear));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glob_q <= 1'b0;
    end else begin
      glob_q <= glob_d;
    end
  end

  assign flags_o = flags_q;
  assign glob_o  = glob_q;

endmodule

// File: rtl/nmi_guard_timer.sv
module nmi_guard_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pending_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wdrst_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fired_q, fired_d;
  logic             reached, cnt_en, pulse;

  always_comb begin
    reached = (cnt_q >= period_i);
    cnt_en  = pending_i & ~reached;
    pulse   = pending_i & reached & ~fired_q;
  end

  always_comb begin
    if (!pending_i) begin
      cnt_d = '0;
    end else if (cnt_en) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_d = cnt_q;
    end
    fired_d = pending_i & (fired_q | pulse);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      fired_q <= fired_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign wdrst_o = pulse;

endmodule

// File: rtl/nmi_guard.sv
module nmi_guard
  import nmi_guard_pkg::*;
#(
  parameter int unsigned NUM_SRC    = 4,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned PERIOD_RST = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_SRC-1:0]    src_i,
  input  logic [REG_ADDR_W-1:0] reg_addr_i,
  input  logic                  reg_wr_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  output logic [DATA_W-1:0]     reg_rdata_o,
  output logic                  nmi_req_o,
  output logic                  nmi_wdrst_o
);

  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_sync_n;
  logic                   enable_q;
  logic [CNT_W-1:0]       period_q;
  logic [CNT_W-1:0]       cnt_q;
  logic [NUM_SRC-1:0]     flags_q;
  logic [NUM_SRC-1:0]     clr_mask;
  logic                   clr_glob;
  logic                   glob_q;
  logic                   pending;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe_q[SYNC_STAGES-1];

  nmi_guard_regif #(
    .NUM_SRC   (NUM_SRC),
    .CNT_W     (CNT_W),
    .DATA_W    (DATA_W),
    .PERIOD_RST(PERIOD_RST)
  ) regif_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .addr_i    (reg_addr_i),
    .wr_i      (reg_wr_i),
    .wdata_i   (reg_wdata_i),
    .flags_i   (flags_q),
    .glob_i    (glob_q),
    .cnt_i     (cnt_q),
    .enable_o  (enable_q),
    .period_o  (period_q),
    .clr_mask_o(clr_mask),
    .clr_glob_o(clr_glob),
    .rdata_o   (reg_rdata_o)
  );

  nmi_guard_flags #(
    .NUM_SRC(NUM_SRC)
  ) flags_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .enable_i  (enable_q),
    .src_i     (src_i),
    .clr_mask_i(clr_mask),
    .clr_glob_i(clr_glob),
    .flags_o   (flags_q),
    .glob_o    (glob_q)
  );

  assign pending = |flags_q;

  nmi_guard_timer #(
    .CNT_W(CNT_W)
  ) timer_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .pending_i(pending),
    .period_i (period_q),
    .cnt_o    (cnt_q),
    .wdrst_o  (nmi_wdrst_o)
  );

  assign nmi_req_o = glob_q;

endmodule

// File: rtl/nmi_guard_chk.sv
module nmi_guard_chk #(
  parameter int unsigned NUM_SRC = 4,
  parameter int unsigned CNT_W   = 16
) (
  input logic               clk_i,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src,
  input logic [NUM_SRC-1:0] flags,
  input logic               glob,
  input logic               enable,
  input logic [CNT_W-1:0]   cnt,
  input logic [CNT_W-1:0]   period,
  input logic               wdrst
);

  assert_enable_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    enable |=> enable);

  assert_no_flag_when_off_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    !enable |=> (flags == '0));

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assert_set_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
      (enable && src[i]) |=> flags[i]);
  end

  assert_glob_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (glob && (flags != '0)) |=> glob);

  assert_count_step_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((flags != '0) && (cnt < period)) |=> (cnt == $past(cnt) + 1'b1));

  assert_wdrst_single_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    wdrst |=> !wdrst);

  assert_wdrst_needs_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    wdrst |-> ((flags != '0) && (cnt >= period)));

  assert_count_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    (flags == '0) |=> (cnt == '0));

endmodule

bind nmi_guard nmi_guard_chk #(
  .NUM_SRC(NUM_SRC),
  .CNT_W  (CNT_W)
) chk_i (
  .clk_i (clk_i),
  .rst_n (rst_sync_n),
  .src   (src_i),
  .flags (flags_q),
  .glob  (glob_q),
  .enable(enable_q),
  .cnt   (cnt_q),
  .period(period_q),
  .wdrst (nmi_wdrst_o)
);

// File: tb/nmi_guard_tb_top.sv
module nmi_guard_tb_top;

  localparam int NSRC = 4;
  localparam int DW   = 16;

  logic            clk;
  logic            rst_n;
  logic [NSRC-1:0] src;
  logic [2:0]      addr;
  logic            wr;
  logic [DW-1:0]   wdata;
  logic [DW-1:0]   rdata;
  logic            req;
  logic            wdrst;

  int  n_tests;
  int  n_fail;
  bit  done;

  nmi_guard dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .src_i      (src),
    .reg_addr_i (addr),
    .reg_wr_i   (wr),
    .reg_wdata_i(wdata),
    .reg_rdata_o(rdata),
    .nmi_req_o  (req),
    .nmi_wdrst_o(wdrst)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [DW-1:0] d);
    addr  = a;
    wdata = d;
    wr    = 1'b1;
    @(negedge clk);
    wr    = 1'b0;
    wdata = '0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [DW-1:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic fire(input logic [NSRC-1:0] m);
    src = m;
    @(negedge clk);
    src = '0;
  endtask

  task automatic clear_all();
    reg_write(3'd2, 16'h001E);
    reg_write(3'd2, 16'h0001);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    reg_read(3'd1, v); check("R1 flag", v, 0);
    reg_read(3'd4, v); check("R1 count", v, 0);
    reg_read(3'd0, v); check("R1 enable", v, 0);
    reg_read(3'd3, v); check("R1 period", v, 16);
    check("R1 req", req, 0);
    check("R1 wdrst", wdrst, 0);
  endtask

  task automatic t_enable();
    logic [DW-1:0] v;
    src = 4'hF;
    repeat (3) @(negedge clk);
    src = '0;
    reg_read(3'd1, v); check("R2 no flag before enable", v, 0);
    check("R2 no req before enable", req, 0);
    reg_write(3'd0, 16'h0001);
    reg_read(3'd0, v); check("R2 enable set", v, 1);
    reg_write(3'd0, 16'h0000);
    reg_read(3'd0, v); check("R2 enable write-once", v, 1);
  endtask

  task automatic t_period();
    logic [DW-1:0] v;
    reg_write(3'd3, 16'h0008);
    reg_read(3'd3, v); check("R11 period readback", v, 8);
  endtask

  task automatic t_set_and_ack();
    logic [DW-1:0] v;
    fire(4'b0010);
    reg_read(3'd1, v); check("R3 flag and global", v, 16'h0005);
    check("R3 req high", req, 1);
    reg_write(3'd1, 16'h0000);
    reg_read(3'd1, v); check("R4 flag write ignored", v, 16'h0005);
    reg_write(3'd2, 16'h0001);
    reg_read(3'd1, v); check("R7 global held while pending", v, 16'h0005);
    check("R7 req held", req, 1);
    reg_write(3'd2, 16'h0004);
    reg_read(3'd1, v); check("R5 source cleared", v, 16'h0001);
    reg_write(3'd2, 16'h0001);
    reg_read(3'd1, v); check("R7 global cleared", v, 0);
    check("R7 req low", req, 0);
    @(negedge clk);
  endtask

  task automatic t_partial();
    logic [DW-1:0] v;
    fire(4'b0011);
    reg_read(3'd1, v); check("R3 two sources", v, 16'h0007);
    reg_write(3'd2, 16'h0002);
    reg_read(3'd1, v); check("R5 others untouched", v, 16'h0005);
    clear_all();
  endtask

  task automatic t_set_wins();
    logic [DW-1:0] v;
    src = 4'b0010;
    reg_write(3'd2, 16'h0004);
    src = '0;
    reg_read(3'd1, v); check("R6 set beats clear", v, 16'h0005);
    clear_all();
    reg_read(3'd1, v); check("R6 cleared afterwards", v, 0);
  endtask

  task automatic t_counter();
    logic [DW-1:0] v;
    fire(4'b0001);
    reg_read(3'd4, v); check("R8 count starts at 0", v, 0);
    repeat (3) @(negedge clk);
    reg_read(3'd4, v); check("R8 count after 3", v, 3);
    for (int k = 4; k <= 10; k++) begin
      @(negedge clk);
      check($sformatf("R9 pulse at step %0d", k), wdrst, (k == 8) ? 1 : 0);
    end
    reg_read(3'd4, v); check("R9 count holds", v, 8);
    reg_write(3'd2, 16'h0002);
    @(negedge clk);
    reg_read(3'd4, v); check("R10 count back to zero", v, 0);
    reg_write(3'd2, 16'h0001);
    reg_write(3'd3, 16'h0002);
    fire(4'b1000);
    check("R10 no pulse at 0", wdrst, 0);
    @(negedge clk);
    check("R10 no pulse at 1", wdrst, 0);
    @(negedge clk);
    check("R10 second episode pulse", wdrst, 1);
    @(negedge clk);
    check("R9 pulse single cycle", wdrst, 0);
    clear_all();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    n_tests = 0;
    n_fail  = 0;
    done    = 1'b0;
    rst_n   = 1'b0;
    src     = '0;
    addr    = '0;
    wr      = 1'b0;
    wdata   = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_enable();
    t_period();
    t_set_and_ack();
    t_partial();
    t_set_wins();
    t_counter();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule